// File: doc/BRIEF.md
# Status Channel Calendar Sequencer

This block drives the two-bit flow-control status lane of a packet interface in the SPI-4.2 style. It walks a programmable calendar. Each calendar slot names one port, and in every clock cycle the block sends the two-bit fill status of the port that the current slot names. After a programmable number of full passes over the calendar, it sends a DIP-2 check word and then a `11` framing word. The framing word marks the boundary between frames.

The length of the calendar is set in steps of four slots. The repeat count uses a plus-one encoding. New length and repeat values are adopted only when a framing word goes out, so a frame is never cut short. Two diagnostic controls are provided. One replaces the frames with a continuous training pattern. The other is a single pulse that corrupts exactly one future DIP-2 word, so that a receive-side checker can be tested.

Top module: `stat_cal_seq`

## Requirements
- R1: While `rst_ni` is low, `stat_o` is `11`. After reset, the first frame uses a length field of 1 (8 slots) and a repeat field of 0 (one pass), and it starts with slot 0 at the first rising edge after reset is released.
- R2: Let L = (`cal_len_i` + 1) × 4. The slots go out in the order 0 to L−1. Slot k sends the status of the port whose number is held in `cal_tbl_i[k*PID_W +: PID_W]`. The table is read when the slot is sent.
- R3: Port p's status is `port_stat_i[2p+1:2p]`. The values 00 (starving), 01 (hungry) and 10 (satisfied) are sent unchanged. A port value of 11 is sent as 10, so a slot word is never `11`.
- R4: One frame is (`cal_rep_i` + 1) full passes over the calendar, followed by one DIP-2 word, followed by one `11` framing word.
- R5: A 2-bit accumulator is cleared when the framing word is sent. For each slot word w, the accumulator becomes {acc[0], acc[1]} XOR w. The DIP-2 word sent is the bitwise inverse of the accumulator.
- R6: The length and repeat inputs are captured only in the cycle in which the framing word is sent, or at reset. Changing them at any other time has no effect on the frame in progress.
- R7: A length value that gives fewer than NUM_PORTS slots is not adopted at a frame boundary. The previous length stays in use, while the repeat value is still taken.
- R8: While `force_train_i` is high, `stat_o` repeats TRAIN_RUN words of `00` followed by TRAIN_RUN words of `11`, beginning with the `00` run. On release, the block sends a framing word and then starts a new frame.
- R9: A pulse on `err_ins_i` makes the next DIP-2 word go out with both bits flipped. Only that one word is affected. A pulse that arrives in the cycle a DIP-2 word is sent applies to the following DIP-2 word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Status lane clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| port_stat_i | input | 2*NUM_PORTS | Per-port two-bit fill status |
| cal_tbl_i | input | 4*2^LEN_W*PID_W | Slot-to-port table, one PID_W entry per slot |
| cal_len_i | input | LEN_W | Calendar length field, slots = (value+1)*4 |
| cal_rep_i | input | REP_W | Passes per frame minus one |
| force_train_i | input | 1 | Send the training pattern continuously |
| err_ins_i | input | 1 | Single pulse: corrupt the next DIP-2 word |
| stat_o | output | 2 | Registered status lane word |

## Verification
The assertions take for granted that NUM_PORTS is no more than 8. With that limit, the reset length of 8 slots already meets the port-count rule. They also take for granted that `err_ins_i` is a pulse and is not held high, because a held level would keep the pending error set across every frame. The stimulus drives all inputs on the falling edge. It pulses `err_ins_i` for single cycles only, and it keeps the length and repeat fields small so that many frame boundaries fall inside the run. It also deliberately applies length values that are too short, and it changes fields in the middle of a frame.

// File: rtl/stat_cal_pkg.sv
package stat_cal_pkg;
  typedef enum logic [1:0] {PH_SLOT, PH_DIP, PH_FRAME} phase_e;

  localparam logic [1:0] W_FRAME = 2'b11;

  // reserved 11 on a port is reported as satisfied
  function automatic logic [1:0] enc_stat(input logic [1:0] s);
    return (s == 2'b11) ? 2'b10 : s;
  endfunction
endpackage

// File: rtl/stat_cal_ctrl.sv
module stat_cal_ctrl
  import stat_cal_pkg::*;
#(
  parameter int unsigned LEN_W     = 6,
  parameter int unsigned REP_W     = 8,
  parameter int unsigned NUM_PORTS = 8,
  localparam int unsigned IDX_W    = LEN_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             force_train_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [REP_W-1:0] rep_i,
  output phase_e           phase_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam int unsigned MIN_LAST = (NUM_PORTS > 0) ? NUM_PORTS - 1 : 0;

  phase_e           phase_q;
  logic [IDX_W-1:0] idx_q;
  logic [REP_W-1:0] rep_cnt_q, rep_q;
  logic [LEN_W-1:0] len_q;
  logic             len_ok;
  logic             last_slot;

  assign len_ok    = {1'b0, len_i, 2'b11} >= (IDX_W+1)'(MIN_LAST);
  assign last_slot = idx_q == {len_q, 2'b11};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_SLOT;
      idx_q     <= '0;
      rep_cnt_q <= '0;
      len_q     <= LEN_W'(1);
      rep_q     <= '0;
    end else if (force_train_i) begin
      phase_q <= PH_FRAME;
    end else begin
      unique case (phase_q)
        PH_SLOT: begin
          if (last_slot) begin
            idx_q <= '0;
            if (rep_cnt_q == rep_q) begin
              rep_cnt_q <= '0;
              phase_q   <= PH_DIP;
            end else begin
              rep_cnt_q <= rep_cnt_q + 1'b1;
            end
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        PH_DIP: phase_q <= PH_FRAME;
        default: begin
          phase_q   <= PH_SLOT;
          idx_q     <= '0;
          rep_cnt_q <= '0;
          rep_q     <= rep_i;
          if (len_ok) len_q <= len_i;
        end
      endcase
    end
  end

  assign phase_o = phase_q;
  assign idx_o   = idx_q;

  a_r6_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_FRAME || force_train_i) |=> ($stable(len_q) && $stable(rep_q)));

  a_r7_len_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, len_q, 2'b11} >= (IDX_W+1)'(MIN_LAST));
endmodule

// File: rtl/stat_cal_slot_mux.sv
module stat_cal_slot_mux
  import stat_cal_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned LEN_W     = 6,
  parameter int unsigned PID_W     = 3,
  localparam int unsigned IDX_W    = LEN_W + 2,
  localparam int unsigned SLOTS    = 1 << IDX_W,
  localparam int unsigned PSPAN    = 1 << PID_W
) (
  input  logic [2*NUM_PORTS-1:0] port_stat_i,
  input  logic [SLOTS*PID_W-1:0] tbl_i,
  input  logic [IDX_W-1:0]       idx_i,
  output logic [1:0]             word_o
);
  logic [1:0]       ps [PSPAN];
  logic [PID_W-1:0] pid;

  for (genvar p = 0; p < PSPAN; p++) begin : g_port
    if (p < NUM_PORTS) begin : g_live
      assign ps[p] = port_stat_i[2*p +: 2];
    end else begin : g_absent
      assign ps[p] = 2'b00;
    end
  end

  assign pid    = tbl_i[int'(idx_i)*PID_W +: PID_W];
  assign word_o = enc_stat(ps[pid]);
endmodule

// File: rtl/stat_cal_dip.sv
module stat_cal_dip (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       upd_i,
  input  logic [1:0] word_i,
  input  logic       dip_emit_i,
  input  logic       err_ins_i,
  output logic [1:0] dip_word_o
);
  logic [1:0] acc_q;
  logic       err_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q      <= '0;
      err_pend_q <= 1'b0;
    end else begin
      if (clr_i)      acc_q <= '0;
      else if (upd_i) acc_q <= {acc_q[0], acc_q[1]} ^ word_i;
      err_pend_q <= (dip_emit_i ? 1'b0 : err_pend_q) | err_ins_i;
    end
  end

  assign dip_word_o = ~acc_q ^ {2{err_pend_q}};

  a_r9_pend_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dip_emit_i && !err_ins_i) |=> !err_pend_q);

  a_r5_acc_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> acc_q == 2'b00);
endmodule

// File: rtl/stat_cal_seq.sv
module stat_cal_seq
  import stat_cal_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned LEN_W     = 6,
  parameter int unsigned REP_W     = 8,
  parameter int unsigned TRAIN_RUN = 10,
  localparam int unsigned PID_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int unsigned IDX_W    = LEN_W + 2,
  localparam int unsigned SLOTS    = 1 << IDX_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [2*NUM_PORTS-1:0] port_stat_i,
  input  logic [SLOTS*PID_W-1:0] cal_tbl_i,
  input  logic [LEN_W-1:0]       cal_len_i,
  input  logic [REP_W-1:0]       cal_rep_i,
  input  logic                   force_train_i,
  input  logic                   err_ins_i,
  output logic [1:0]             stat_o
);
  localparam int unsigned TCNT_W = $clog2(2 * TRAIN_RUN);

  phase_e            phase;
  logic [IDX_W-1:0]  idx;
  logic [1:0]        slot_word, dip_word;
  logic [TCNT_W-1:0] tcnt_q;

  stat_cal_ctrl #(.LEN_W(LEN_W), .REP_W(REP_W), .NUM_PORTS(NUM_PORTS)) u_ctrl (
    .clk_i, .rst_ni, .force_train_i,
    .len_i(cal_len_i), .rep_i(cal_rep_i),
    .phase_o(phase), .idx_o(idx)
  );

  stat_cal_slot_mux #(.NUM_PORTS(NUM_PORTS), .LEN_W(LEN_W), .PID_W(PID_W)) u_mux (
    .port_stat_i, .tbl_i(cal_tbl_i), .idx_i(idx), .word_o(slot_word)
  );

  stat_cal_dip u_dip (
    .clk_i, .rst_ni,
    .clr_i(phase == PH_FRAME && !force_train_i),
    .upd_i(phase == PH_SLOT && !force_train_i),
    .word_i(slot_word),
    .dip_emit_i(phase == PH_DIP && !force_train_i),
    .err_ins_i,
    .dip_word_o(dip_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_o <= W_FRAME;
      tcnt_q <= '0;
    end else if (force_train_i) begin
      stat_o <= (tcnt_q < TCNT_W'(TRAIN_RUN)) ? 2'b00 : 2'b11;
      tcnt_q <= (tcnt_q == TCNT_W'(2*TRAIN_RUN-1)) ? '0 : tcnt_q + 1'b1;
    end else begin
      tcnt_q <= '0;
      unique case (phase)
        PH_SLOT: stat_o <= slot_word;
        PH_DIP:  stat_o <= dip_word;
        default: stat_o <= W_FRAME;
      endcase
    end
  end

  a_r3_slot_not_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_SLOT && !force_train_i) |=> stat_o != 2'b11);

  a_r4_frame_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_FRAME && !force_train_i) |=> stat_o == W_FRAME);

  a_r8_train_levels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_train_i |=> (stat_o == 2'b00 || stat_o == 2'b11));
endmodule

// File: tb/stat_cal_seq_tb.sv
module stat_cal_seq_tb_top;
  localparam int NP = 8, LW = 6, RW = 8, TR = 10, PW = 3;
  localparam int SL = 4 << LW;

  logic              clk = 1'b0, rst_n = 1'b0;
  logic [2*NP-1:0]   stat_i = '0;
  logic [SL*PW-1:0]  tbl = '0;
  logic [LW-1:0]     len_i = LW'(1);
  logic [RW-1:0]     rep_i = '0;
  logic              force_t = 1'b0, err_i = 1'b0;
  logic [1:0]        stat_o;

  int checks = 0, errors = 0;
  bit done = 0;
  string scen = "R1";

  // reference model state
  int         q[$];
  int         m_len, m_rep, tcnt;
  logic [1:0] exp_w, acc;
  bit         pend;
  string      tag = "R1";

  always #10 clk = ~clk;

  stat_cal_seq #(.NUM_PORTS(NP), .LEN_W(LW), .REP_W(RW), .TRAIN_RUN(TR)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .port_stat_i(stat_i), .cal_tbl_i(tbl),
    .cal_len_i(len_i), .cal_rep_i(rep_i), .force_train_i(force_t),
    .err_ins_i(err_i), .stat_o(stat_o)
  );

  task automatic build_frame();
    q.delete();
    for (int r = 0; r <= m_rep; r++)
      for (int k = 0; k < (m_len + 1) * 4; k++) q.push_back(k);
    q.push_back(-1);
    q.push_back(-2);
  endtask

  function automatic logic [1:0] slot_val(int k);
    logic [2:0] pid;
    logic [1:0] s;
    pid = tbl[k*PW +: PW];
    s   = stat_i[2*pid +: 2];
    return (s == 2'b11) ? 2'b10 : s;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_len = 1; m_rep = 0; tcnt = 0; acc = 2'b00; pend = 0;
      exp_w = 2'b11; tag = "R1";
      build_frame();
    end else begin
      if (force_t) begin
        exp_w = (tcnt < TR) ? 2'b00 : 2'b11;
        tcnt  = (tcnt + 1) % (2 * TR);
        tag   = "R8";
        q.delete();
        q.push_back(-2);
      end else begin
        int it;
        tcnt = 0;
        it = q.pop_front();
        if (it >= 0) begin
          exp_w = slot_val(it);
          acc   = {acc[0], acc[1]} ^ exp_w;
          tag   = "R2";
        end else if (it == -1) begin
          exp_w = ~acc ^ {2{pend}};
          pend  = 0;
          tag   = "R5";
        end else begin
          exp_w = 2'b11;
          acc   = 2'b00;
          tag   = "R4";
          if ((int'(len_i) + 1) * 4 >= NP) m_len = int'(len_i);
          m_rep = int'(rep_i);
          build_frame();
        end
      end
      if (err_i) pend = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (stat_o !== exp_w) begin
        errors++;
        $display("FAIL %s (%s) got %b exp %b at %0t", tag, scen, stat_o, exp_w, $time);
      end
    end
  end

  task automatic run(int n, bit rs, bit rcfg, bit rerr);
    repeat (n) begin
      @(negedge clk);
      if (rs) stat_i = 16'($urandom);
      if (rcfg && ($urandom % 7 == 0)) begin
        len_i = LW'($urandom % 8);
        rep_i = RW'($urandom % 4);
      end
      err_i = rerr && ($urandom % 15 == 0);
    end
    @(negedge clk);
    err_i = 1'b0;
  endtask

  task automatic set_tbl(int mul, int add);
    for (int k = 0; k < SL; k++) tbl[k*PW +: PW] = 3'((k * mul + add) % NP);
  endtask

  initial begin
    set_tbl(1, 0);
    stat_i = 16'hE4_1B;
    repeat (3) @(negedge clk);
    // R1: reset value
    checks++;
    if (stat_o !== 2'b11) begin
      errors++;
      $display("FAIL R1 reset got %b exp 11", stat_o);
    end
    rst_n = 1'b1;
    scen = "R1"; run(30, 0, 0, 0);
    scen = "R2"; set_tbl(3, 1); len_i = 6'd4; run(120, 1, 0, 0);
    scen = "R3"; stat_i = '1; run(40, 0, 0, 0); run(60, 1, 0, 0);
    scen = "R4"; len_i = 6'd2; rep_i = 8'd2; run(130, 1, 0, 0);
    scen = "R5"; set_tbl(5, 2); len_i = 6'd1; rep_i = 8'd1; run(120, 1, 0, 0);
    scen = "R6"; run(300, 1, 1, 0);
    scen = "R7"; len_i = 6'd0; rep_i = 8'd0; run(60, 1, 0, 0);
    len_i = 6'd3; run(60, 1, 0, 0);
    scen = "R8"; force_t = 1'b1; run(55, 1, 0, 0);
    force_t = 1'b0; run(60, 1, 0, 0);
    force_t = 1'b1; run(7, 1, 0, 0);
    force_t = 1'b0; run(40, 1, 0, 0);
    scen = "R9"; len_i = 6'd1; rep_i = 8'd0;
    @(negedge clk); err_i = 1'b1; @(negedge clk); err_i = 1'b0;
    run(40, 1, 0, 0);
    run(400, 1, 1, 1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule